// File: doc/BRIEF.md
# Shared-Word Interrupt Aggregator

This block collects a small group of interrupt request lines into a single parent interrupt output. Control and status share one 32-bit register on a simple memory-mapped port. For every source, the low half of the word holds an enable bit and the high half holds a latched status bit. Each status bit sits exactly sixteen positions above its enable bit. Two parameters place the sources: `NUM_SRC` gives their number and `BASE` gives the bit position of the first one.

A rising edge on a request line latches that source's status bit, whether or not the source is enabled. Software reads the whole word combinationally. It clears handled causes by writing ones to their status bits. It masks or unmasks sources by rewriting the enable field, writing zeros to the status field so that no pending cause is lost. The parent output is the OR of all status bits whose enable is set, taken through one register. It stays high while any enabled cause is still latched, which is what a level-type downstream handler expects. `BASE + NUM_SRC` must not exceed 16.

Top module: `irq_word_aggregator`

## Requirements
- R1: After reset, every enable bit and every status bit reads 0 and `irq_out` is 0.
- R2: A 0-to-1 change of `irq_req[n]` from one clock to the next sets status bit `BASE+n+16`, whether enable bit `BASE+n` is set or not. A request held high does not set the bit again after it has been cleared.
- R3: A write to `REG_ADDR` with a 1 in status bit `BASE+n+16` clears that status bit. A 0 in that bit leaves it unchanged.
- R4: When a rising edge and a clearing write hit the same source in the same cycle, the status bit ends up set.
- R5: A write to `REG_ADDR` loads enable bits `BASE+n` from the written data, one per source.
- R6: `irq_out` equals, one clock later, the OR over all sources of (status AND enable).
- R7: `irq_out` stays 1 while any enabled status bit is set. Clearing the enable drops `irq_out` but leaves the status bit set.
- R8: Register bits outside `[BASE+NUM_SRC-1:BASE]` and `[BASE+NUM_SRC+15:BASE+16]` always read 0, and writing them has no effect.
- R9: When `bus_we` is 0, or `bus_addr` differs from `REG_ADDR`, enable and status bits are unchanged apart from new request edges.
- R10: Enable bit `n` of the sources appears at read bit `BASE+n` and status bit `n` at read bit `BASE+n+16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Interrupt request lines, one per source |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read of the register word |
| irq_out | output | 1 | Registered parent interrupt |

## Verification
A request edge or a write applied before clock edge k shows up in `bus_rdata` right after edge k, because the read path has no register. `irq_out` reflects the state that holds after edge k only after edge k+1. The bench drives inputs at the falling edge and samples one time unit after each rising edge. At every edge a reference model updates the register word from the values that were driven. The model's parent-line prediction uses the status and enable values from before that edge, so the one extra register stage on `irq_out` is accounted for.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
    localparam int WORD_W  = 32;
    localparam int STS_OFS = 16;
endpackage

// File: rtl/src_status_bank.sv
module src_status_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] sts;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise     = req_i & ~st_q.req;
        st_d.req = req_i;
        // an edge in the same cycle as a clear wins
        st_d.sts = (st_q.sts & ~clr_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & $past(rise)) == $past(rise)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & $past(clr_i & ~rise)) == '0));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & $past(st_q.sts & ~clr_i)) == $past(st_q.sts & ~clr_i)));
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & clr_i)) |=> ((st_q.sts & $past(rise & clr_i)) == $past(rise & clr_i)));
endmodule

// File: rtl/ctrl_reg_port.sv
module ctrl_reg_port
    import aggr_pkg::*;
#(
    parameter int N        = 7,
    parameter int BASE     = 0,
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [N-1:0]      sts_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      clr_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam logic [WORD_W-1:0] FIELD_MASK =
        ((WORD_W'(1) << N) - WORD_W'(1)) << BASE |
        ((WORD_W'(1) << N) - WORD_W'(1)) << (BASE + STS_OFS);

    typedef struct packed {
        logic [N-1:0] en;
    } ctl_t;

    ctl_t st_d, st_q;
    logic hit;

    always_comb begin
        hit   = we_i && (addr_i == ADDR_W'(REG_ADDR));
        st_d  = st_q;
        clr_o = '0;
        if (hit) begin
            st_d.en = wdata_i[BASE +: N];
            clr_o   = wdata_i[BASE + STS_OFS +: N];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o                         = '0;
        rdata_o[BASE +: N]              = st_q.en;
        rdata_o[BASE + STS_OFS +: N]    = sts_i;
    end

    assign en_o = st_q.en;

    p_en_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (st_q.en == $past(wdata_i[BASE +: N])));
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q.en));
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~FIELD_MASK) == '0);
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sts_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } mrg_t;

    mrg_t st_d, st_q;

    always_comb begin
        st_d.irq = |(sts_i & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.irq == $past(|(sts_i & en_i))));
    p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_i & en_i)) |=> st_q.irq);
endmodule

// File: rtl/irq_word_aggregator.sv
module irq_word_aggregator
    import aggr_pkg::*;
#(
    parameter int NUM_SRC  = 7,
    parameter int BASE     = 0,
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 8'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] sts, en, clr;

    ctrl_reg_port #(.N(NUM_SRC), .BASE(BASE), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .sts_i(sts), .en_o(en), .clr_o(clr), .rdata_o(bus_rdata)
    );

    src_status_bank #(.N(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req), .clr_i(clr), .sts_o(sts)
    );

    irq_merge #(.N(NUM_SRC)) u_merge (
        .clk(clk), .rst_n(rst_n), .sts_i(sts), .en_i(en), .irq_o(irq_out)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && !irq_out));
endmodule

// File: tb/tb_irq_word_aggregator.sv
module tb_irq_word_aggregator;
    localparam int N   = 3;
    localparam int B   = 4;
    localparam int AW  = 8;
    localparam int RA  = 8'h18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [N-1:0] m_en = '0, m_sts = '0, m_prev = '0;
    logic         m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_word_aggregator #(.NUM_SRC(N), .BASE(B), .ADDR_W(AW), .REG_ADDR(RA)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_word(logic [N-1:0] e, logic [N-1:0] s);
        logic [31:0] w = '0;
        for (int i = 0; i < N; i++) begin
            w[B + i]      = e[i];
            w[B + 16 + i] = s[i];
        end
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at falling edge, update model, compare after rising edge
    task automatic step(string tag, logic [N-1:0] req, logic we, logic [AW-1:0] a, logic [31:0] d);
        logic [N-1:0] rise, clr;
        @(negedge clk);
        irq_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        rise   = req & ~m_prev;
        clr    = (we && a == AW'(RA)) ? d[B + 16 +: N] : '0;
        m_irq  = |(m_sts & m_en);
        m_sts  = (m_sts & ~clr) | rise;
        if (we && a == AW'(RA)) m_en = d[B +: N];
        m_prev = req;
        #1;
        check(tag, bus_rdata, exp_word(m_en, m_sts));
        check(tag, {31'd0, irq_out}, {31'd0, m_irq});
    endtask

    function automatic logic [31:0] wr_word(logic [N-1:0] e, logic [N-1:0] c);
        return exp_word(e, c);
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rdata", bus_rdata, 32'd0);
        check("R1 reset irq", {31'd0, irq_out}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: edge latches while disabled, no irq
        step("R2", 3'b001, 0, '0, '0);
        step("R2 hold level", 3'b001, 0, '0, '0);
        // R10: field placement, enable source 0 and 2
        step("R10 R5 enable", 3'b001, 1, AW'(RA), wr_word(3'b101, 3'b000));
        step("R6 irq rises", 3'b001, 0, '0, '0);
        step("R7 level held", 3'b001, 0, '0, '0);
        // R7: mask drops irq, status kept
        step("R7 mask", 3'b001, 1, AW'(RA), wr_word(3'b000, 3'b000));
        step("R7 masked", 3'b001, 0, '0, '0);
        // R3: clear with W1C; held level does not re-set
        step("R3 clear", 3'b001, 1, AW'(RA), wr_word(3'b111, 3'b001));
        step("R2 no reset on level", 3'b001, 0, '0, '0);
        // R4: edge and clear together
        step("R4 edge", 3'b011, 1, AW'(RA), wr_word(3'b111, 3'b010));
        step("R4 after", 3'b011, 0, '0, '0);
        // R9: wrong address and no strobe
        step("R9 bad addr", 3'b011, 1, AW'(RA + 4), 32'hFFFF_FFFF);
        step("R9 no strobe", 3'b011, 0, AW'(RA), 32'hFFFF_FFFF);
        // R8: writes to unused bits ignored, zero status half keeps status
        step("R8 unused", 3'b011, 1, AW'(RA), ~wr_word(3'b111, 3'b111) | wr_word(3'b110, 3'b000));
        step("R3 clear all", 3'b000, 1, AW'(RA), wr_word(3'b110, 3'b111));
        step("R6 settle", 3'b000, 0, '0, '0);

        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] r = N'($urandom);
            logic         w = ($urandom % 3) == 0;
            logic [AW-1:0] a = (($urandom % 4) == 0) ? AW'($urandom) : AW'(RA);
            step("R2 R3 R5 R6 R8 random", r, w, a, $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule